// File: doc/BRIEF.md
# Quarter-Phase Microcoded Strobe Sequencer

This block drives the control strobes of an external memory bus from a small table of microcode. A host loads the table, a 64-entry by 32-bit store, through a plain address, data and write-enable port. A start request then names the index of the first word, and the byte lanes that take part in the access. From that point the sequencer reads one word per bus clock. For each of the four quarter phases of that bus clock, the word sets the level of a chip select, the byte selects and six general-purpose lines.

The block runs on a clock at four times the bus clock rate. A 2-bit quarter counter steps through the phases, and a new word is fetched only when the counter returns to its first quarter. After the fourth quarter of a word whose stop flag is set, the sequencer goes idle. While idle it holds every strobe high. General-purpose line 0 takes a two-bit code for each half of the bus clock. One of its codes defers to a mode-level default input, and another code is reserved and reported through a sticky error flag.

Top module: `qwave_seq`

## Requirements
- R1: A write with `wr_en` high while `busy` is low stores `wr_data` at `wr_addr`, and a later sequence that reaches that index uses the new word.
- R2: A write presented while `busy` is high is discarded, and the stored word at that index keeps its old value.
- R3: With `busy` low, `start` loads the word at `start_idx` and captures `start_lanes`. Quarter 1 appears in the cycle after that clock edge, and each later quarter follows one clock later. While `busy` is high, `start` has no effect.
- R4: Bit numbering is [31:0]. Chip select `cs_n` in quarters 1 to 4 equals word bits 31, 30, 29 and 28 in turn.
- R5: In quarters 1 to 4, each byte select whose `start_lanes` bit was 1 follows word bits 27, 26, 25 and 24 in turn. A lane whose bit was 0 stays high for the whole sequence.
- R6: `gpl[0]` takes code bits [23:22] in quarters 1 and 2 and code bits [21:20] in quarters 3 and 4. Code 2'b10 drives 0, 2'b11 drives 1, and 2'b00 drives `g0_dflt`.
- R7: Code 2'b01 on `gpl[0]` drives `g0_dflt`. In the cycle after such a quarter, `err` goes high and stays high until reset.
- R8: For k from 1 to 5, `gpl[k]` equals word bit 21-2k in quarters 1 and 2, and word bit 20-2k in quarters 3 and 4.
- R9: Word bit 0 is the stop flag. After quarter 4 of a word that has the flag set, `busy` falls. Otherwise the next index follows at once, and index 63 wraps to 0.
- R10: While `busy` is low, `cs_n`, all of `bs_n` and all of `gpl` are high.
- R11: After reset, `busy` and `err` are low and the outputs are in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 6 | Store write index |
| wr_data | input | 32 | Microcode word to store |
| start | input | 1 | Sequence start request |
| start_idx | input | 6 | Index of the first word |
| start_lanes | input | 4 | Byte lanes taking part in the access |
| g0_dflt | input | 1 | Default level for general-purpose line 0 |
| busy | output | 1 | Sequence in progress |
| cs_n | output | 1 | Chip select strobe |
| bs_n | output | 4 | Byte select strobes |
| gpl | output | 6 | General-purpose lines |
| err | output | 1 | Sticky flag for a reserved code |

## Verification
A wrong quarter counter or a stale word register shows up at once in the outputs, within one fast clock. The strobe levels sampled in each quarter stop matching the word bits, so each quarter is compared on its own. Wrong index stepping or a missed stop flag shows within one bus clock. The outputs then carry a different word's pattern, or `busy` stays high when it should be low. A write or start that leaks through while the sequencer runs is harder to see. The bench catches it by replaying the affected index, and by checking that a running sequence keeps its own word order after a mid-run start.

// File: rtl/qwave_pkg.sv
package qwave_pkg;
  localparam int WORD_W  = 32;
  localparam int N_QTR   = 4;
  // vector positions, bit 31 is the first field
  localparam int CST_HI  = 31;
  localparam int BST_HI  = 27;
  localparam int G0A_HI  = 23;
  localparam int G0B_HI  = 21;
  localparam int GX_HI   = 19;
  localparam int STOP_B  = 0;

  typedef logic [1:0] qtr_t;

  typedef enum logic [1:0] {
    G0_DFLT = 2'b00,
    G0_RSV  = 2'b01,
    G0_LOW  = 2'b10,
    G0_HIGH = 2'b11
  } g0_code_e;
endpackage

// File: rtl/qwave_store.sv
module qwave_store #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qwave_qdec.sv
module qwave_qdec
  import qwave_pkg::*;
#(
  parameter int N_GPL = 6
) (
  input  logic [WORD_W-1:0] word,
  input  qtr_t              qtr,
  input  logic              g0_dflt,
  output logic              cs,
  output logic              bsel,
  output logic [N_GPL-1:0]  gpl,
  output logic              rsv_hit
);
  logic [N_QTR-1:0] cs_f;
  logic [N_QTR-1:0] bs_f;
  logic             second;
  g0_code_e         code;

  assign cs_f   = word[CST_HI -: N_QTR];
  assign bs_f   = word[BST_HI -: N_QTR];
  assign second = qtr[1];

  always_comb begin
    cs   = cs_f[2'd3 - qtr];
    bsel = bs_f[2'd3 - qtr];
    code = g0_code_e'(second ? word[G0B_HI -: 2] : word[G0A_HI -: 2]);
    unique case (code)
      G0_LOW:  gpl[0] = 1'b0;
      G0_HIGH: gpl[0] = 1'b1;
      default: gpl[0] = g0_dflt;
    endcase
    rsv_hit = (code == G0_RSV);
  end

  for (genvar k = 1; k < N_GPL; k++) begin : g_line
    localparam int HI = GX_HI - 2 * (k - 1);
    assign gpl[k] = second ? word[HI-1] : word[HI];
  end
endmodule

// File: rtl/qwave_seq.sv
module qwave_seq
  import qwave_pkg::*;
#(
  parameter int AW     = 6,
  parameter int N_LANE = 4,
  parameter int N_GPL  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [AW-1:0]     start_idx,
  input  logic [N_LANE-1:0] start_lanes,
  input  logic              g0_dflt,
  output logic              busy,
  output logic              cs_n,
  output logic [N_LANE-1:0] bs_n,
  output logic [N_GPL-1:0]  gpl,
  output logic              err
);
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic              run_q, run_d;
  qtr_t              qtr_q, qtr_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [N_LANE-1:0] lanes_q, lanes_d;
  logic              err_q, err_d;

  logic [AW-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              store_we;
  logic              dec_cs, dec_bs, dec_rsv;
  logic [N_GPL-1:0]  dec_gpl;
  logic              cur_stop;

  assign store_we = wr_en & ~run_q;
  assign rd_idx   = run_q ? idx_q + 1'b1 : start_idx;
  assign cur_stop = word_q[STOP_B];

  qwave_store #(.AW(AW), .DW(WORD_W)) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (rd_word)
  );

  qwave_qdec #(.N_GPL(N_GPL)) u_dec (
    .word    (word_q),
    .qtr     (qtr_q),
    .g0_dflt (g0_dflt),
    .cs      (dec_cs),
    .bsel    (dec_bs),
    .gpl     (dec_gpl),
    .rsv_hit (dec_rsv)
  );

  always_comb begin
    run_d   = run_q;
    qtr_d   = qtr_q;
    idx_d   = idx_q;
    word_d  = word_q;
    lanes_d = lanes_q;
    err_d   = err_q | (run_q & dec_rsv);
    if (!run_q) begin
      if (start) begin
        run_d   = 1'b1;
        qtr_d   = '0;
        idx_d   = start_idx;
        word_d  = rd_word;
        lanes_d = start_lanes;
      end
    end else if (qtr_q == 2'd3) begin
      qtr_d = '0;
      if (cur_stop) begin
        run_d = 1'b0;
      end else begin
        idx_d  = idx_q + 1'b1;
        word_d = rd_word;
      end
    end else begin
      qtr_d = qtr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q   <= 1'b0;
      qtr_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      lanes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      qtr_q   <= qtr_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      lanes_q <= lanes_d;
      err_q   <= err_d;
    end
  end

  assign busy = run_q;
  assign err  = err_q;
  assign cs_n = run_q ? dec_cs : 1'b1;
  assign bs_n = run_q ? (~lanes_q | {N_LANE{dec_bs}}) : '1;
  assign gpl  = run_q ? dec_gpl : '1;
endmodule

// File: rtl/qwave_chk.sv
module qwave_chk #(
  parameter int AW     = 6,
  parameter int N_LANE = 4,
  parameter int N_GPL  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic [1:0]        qtr,
  input logic [AW-1:0]     idx,
  input logic              stop_flag,
  input logic              cs_n,
  input logic [N_LANE-1:0] bs_n,
  input logic [N_GPL-1:0]  gpl,
  input logic              err
);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && (&bs_n) && (&gpl)));

  // R3
  qtr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && qtr != 2'd3 |=> busy && qtr == $past(qtr) + 2'd1);

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && qtr != 2'd3 |=> $stable(idx));

  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && qtr == 2'd3 && stop_flag |=> !busy);

  // R9
  chain_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && qtr == 2'd3 && !stop_flag |=> busy && qtr == 2'd0 && idx == $past(idx) + 1'b1);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (qtr == 2'd0 || qtr == 2'd2) |=> $stable(gpl[N_GPL-1:1]));
endmodule

bind qwave_seq qwave_chk #(.AW(AW), .N_LANE(N_LANE), .N_GPL(N_GPL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .start     (start),
  .qtr       (qtr_q),
  .idx       (idx_q),
  .stop_flag (cur_stop),
  .cs_n      (cs_n),
  .bs_n      (bs_n),
  .gpl       (gpl),
  .err       (err)
);

// File: tb/sim_qwave_seq.sv
module sim_qwave_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic [5:0]  start_idx = '0;
  logic [3:0]  start_lanes = '0;
  logic        g0_dflt = 1'b0;
  logic        busy, cs_n, err;
  logic [3:0]  bs_n;
  logic [5:0]  gpl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] model [64];
  bit err_exp = 1'b0;

  always #2 clk = ~clk;

  qwave_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_idx(start_idx), .start_lanes(start_lanes), .g0_dflt(g0_dflt),
    .busy(busy), .cs_n(cs_n), .bs_n(bs_n), .gpl(gpl), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic db(input logic [31:0] w, input int k);
    return w[31-k];
  endfunction

  function automatic logic [1:0] g0code(input logic [31:0] w, input int q);
    return (q < 2) ? {db(w, 8), db(w, 9)} : {db(w, 10), db(w, 11)};
  endfunction

  function automatic logic [10:0] exp_pins(input logic [31:0] w, input int q,
                                           input logic [3:0] ln, input logic d);
    logic [3:0] b;
    logic [5:0] g;
    logic [1:0] c;
    for (int i = 0; i < 4; i++) b[i] = ln[i] ? db(w, 4 + q) : 1'b1;
    c = g0code(w, q);
    g[0] = (c == 2'b10) ? 1'b0 : (c == 2'b11) ? 1'b1 : d;
    for (int k = 1; k < 6; k++) g[k] = (q < 2) ? db(w, 12 + 2*(k-1)) : db(w, 13 + 2*(k-1));
    return {db(w, q), b, g};
  endfunction

  function automatic logic [31:0] mkw(input logic [3:0] c, input logic [3:0] b, input logic [1:0] a,
                                      input logic [1:0] h, input logic [9:0] x, input logic s);
    return {c, b, a, h, x, 9'b0, s};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // mode: 0 plain, 1 write attempt mid-run, 2 start attempt mid-run
  task automatic run(input logic [5:0] idx, input logic [3:0] ln, input int mode,
                     input logic [5:0] xa, input logic [31:0] xd);
    logic [5:0]  cur;
    logic [31:0] w;
    bit first;
    @(negedge clk);
    start = 1'b1; start_idx = idx; start_lanes = ln;
    @(negedge clk);
    start = 1'b0;
    cur = idx;
    first = 1'b1;
    forever begin
      w = model[cur];
      for (int q = 0; q < 4; q++) begin
        if (q > 0) @(negedge clk);
        wr_en = 1'b0;
        start = 1'b0;
        check("R4 R5 R6 R8 pins", {21'b0, cs_n, bs_n, gpl}, {21'b0, exp_pins(w, q, ln, g0_dflt)});
        check("R3 busy", {31'b0, busy}, 32'd1);
        check("R7 err", {31'b0, err}, {31'b0, err_exp});
        if (g0code(w, q) == 2'b01) err_exp = 1'b1;
        if (first && q == 1 && mode == 1) begin
          wr_en = 1'b1; wr_addr = xa; wr_data = xd;
        end
        if (first && q == 1 && mode == 2) begin
          start = 1'b1; start_idx = xa; start_lanes = 4'hF;
        end
      end
      @(negedge clk);
      first = 1'b0;
      if (db(w, 31)) break;
      cur = cur + 1'b1;
    end
    check("R9 R10 stop", {31'b0, busy}, 32'd0);
    check("R10 idle pins", {21'b0, cs_n, bs_n, gpl}, {21'b0, 11'h7FF});
    check("R7 err after", {31'b0, err}, {31'b0, err_exp});
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    // R11 in reset
    check("R11 busy", {31'b0, busy}, 32'd0);
    check("R11 err", {31'b0, err}, 32'd0);
    check("R11 pins", {21'b0, cs_n, bs_n, gpl}, {21'b0, 11'h7FF});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", {30'b0, busy, err}, 32'd0);

    // R1: fill the store
    for (int a = 0; a < 64; a++) begin
      r = $urandom;
      r[0] = (($urandom % 4) == 0) || (a % 8 == 7);
      wr(a[5:0], r);
    end
    wr(6'd10, mkw(4'b0111, 4'b1010, 2'b10, 2'b11, 10'b1001110001, 1'b0));
    wr(6'd11, mkw(4'b1100, 4'b0101, 2'b00, 2'b00, 10'b0110100111, 1'b1));
    wr(6'd63, mkw(4'b1010, 4'b0011, 2'b11, 2'b10, 10'b1111000011, 1'b0));
    wr(6'd0,  mkw(4'b0001, 4'b1000, 2'b10, 2'b00, 10'b0000111100, 1'b1));
    wr(6'd20, mkw(4'b0110, 4'b1001, 2'b01, 2'b11, 10'b0101010101, 1'b1));

    // R4 R5 R6 R8 R9 with both defaults
    g0_dflt = 1'b0; run(6'd10, 4'hF, 0, 6'd0, 32'd0);
    g0_dflt = 1'b1; run(6'd10, 4'hF, 0, 6'd0, 32'd0);
    // R5 partial lanes
    run(6'd11, 4'b0101, 0, 6'd0, 32'd0);
    // R9 wrap from 63 to 0
    run(6'd63, 4'b1110, 0, 6'd0, 32'd0);
    // R2 refused write to index 11, then replay 11
    run(6'd10, 4'hF, 1, 6'd11, 32'hFFFF_FFFE);
    run(6'd11, 4'hF, 0, 6'd0, 32'd0);
    // R3 start while busy ignored
    run(6'd10, 4'b0011, 2, 6'd63, 32'd0);
    check("R7 no error yet", {31'b0, err}, 32'd0);
    // R7 reserved code
    g0_dflt = 1'b0; run(6'd20, 4'hF, 0, 6'd0, 32'd0);
    check("R7 sticky set", {31'b0, err}, 32'd1);
    // R1 rewrite then use
    wr(6'd20, mkw(4'b1001, 4'b0110, 2'b11, 2'b10, 10'b1010101010, 1'b1));
    run(6'd20, 4'hF, 0, 6'd0, 32'd0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      if (($urandom % 3) == 0) begin
        logic [5:0] a;
        a = 6'($urandom);
        r = $urandom;
        r[0] = (($urandom % 4) == 0) || (a % 8 == 7) || (a == 6'd11) || (a == 6'd0);
        if (a == 6'd10 || a == 6'd63) r[0] = 1'b1;
        wr(a, r);
      end
      g0_dflt = 1'($urandom);
      run(6'($urandom), 4'($urandom), int'($urandom % 3), 6'($urandom), $urandom);
    end
    check("R7 sticky end", {31'b0, err}, 32'd1);
    finish_up();
  end
endmodule